// File: doc/BRIEF.md
# Debounced Up/Down Stepper With Autoscan

This block converts two active-low pushbutton lines into a saturating position value for a digital wiper or setting register. A press is accepted only after the line has stayed low for a full debounce interval. An accepted press moves the position by one step. If the button is still held after a longer hold threshold, the block steps once more and then enters automatic repeat, issuing one step per scan period until the line goes high again.

All timing is counted in ticks from an internal prescaler. With the default setting one tick is 1 ms. The two raw lines pass through two-flop synchronizers. Pressing both buttons at once is treated as a conflict: the block ignores it and waits until both lines are released. After any release, the lines must stay high for a guard interval before the next press is taken.

Top module: `stepper_autoscan`

## Requirements
- R1: A line is pressed when it reads 0 and idle when it reads 1. A step happens only after a line has been low without a break for DEB_TICKS ticks. Every step coincides with a prescaler tick, and one tick is CLK_PER_TICK clock cycles.
- R2: A low pulse shorter than DEB_TICKS ticks produces no step.
- R3: If the up line is still low AS_START_TICKS ticks after the first step, a second step is issued and auto-repeat begins.
- R4: During auto-repeat, one further step is issued every AS_PERIOD_TICKS ticks while the line stays low. Releasing the line stops the steps at once.
- R5: The down line behaves the same way as the up line, with identical timing, but it decrements the position.
- R6: Each change of the position is exactly one code. Holding the up line never lowers the position, and holding the down line never raises it.
- R7: The position saturates. An up step at code 2^POS_W-1 and a down step at code 0 leave the position unchanged.
- R8: While both lines are low, no step is issued. After both have been low together, no step follows until both lines have been released.
- R9: After a release, the lines must stay high for REL_TICKS ticks before a new press is taken. A press made during this interval produces no step.
- R10: Reset loads the position to midscale, 2^(POS_W-1), and puts the controller in its idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_n | input | 1 | Raw up button line, low when pressed |
| dn_n | input | 1 | Raw down button line, low when pressed |
| pos | output | POS_W | Current position code |

## Verification
On every cycle the assertions check the following: each position change is a single code, steps happen only on ticks, at most one direction steps at a time, steps are blocked while both lines are pressed, the position holds at its upper limit, and the position does not rise after the up line has been high for several cycles. The bench scenarios cover the behaviour that depends on timing windows: the debounce threshold and glitch rejection, the hold delay before auto-repeat, the repeat rate, the release guard, and saturation at both ends after long holds.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEB,
        ST_HOLD,
        ST_SCAN,
        ST_REL,
        ST_BOTH
    } step_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] pressed
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= 2'b11;
            else        sh_q <= {sh_q[0], raw_n[i]};
        end
        assign pressed[i] = ~sh_q[1];
    end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int CLK_PER_TICK = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == PW'(CLK_PER_TICK - 1)) cnt_d = '0;
        else                                cnt_d = cnt_q + 1'b1;
    end
    assign tick = (cnt_q == PW'(CLK_PER_TICK - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/step_fsm.sv
module step_fsm
    import stepper_pkg::*;
#(
    parameter int DEB_TICKS       = 11,
    parameter int AS_START_TICKS  = 800,
    parameter int AS_PERIOD_TICKS = 250,
    parameter int REL_TICKS       = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic up_p,
    input  logic dn_p,
    output logic step_up,
    output logic step_dn
);
    localparam int M1   = (DEB_TICKS > AS_START_TICKS) ? DEB_TICKS : AS_START_TICKS;
    localparam int M2   = (AS_PERIOD_TICKS > REL_TICKS) ? AS_PERIOD_TICKS : REL_TICKS;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        step_state_e   state;
        logic          dir_up;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t r_d, r_q;
    logic          act;
    logic [CW-1:0] lim;

    always_comb begin
        r_d     = r_q;
        step_up = 1'b0;
        step_dn = 1'b0;
        act     = r_q.dir_up ? up_p : dn_p;
        case (r_q.state)
            ST_DEB:  lim = CW'(DEB_TICKS - 1);
            ST_HOLD: lim = CW'(AS_START_TICKS - 1);
            default: lim = CW'(AS_PERIOD_TICKS - 1);
        endcase
        case (r_q.state)
            ST_IDLE: begin
                if (up_p && dn_p) begin
                    r_d.state = ST_BOTH;
                end else if (up_p || dn_p) begin
                    r_d.state  = ST_DEB;
                    r_d.dir_up = up_p;
                    r_d.cnt    = '0;
                end
            end
            ST_DEB, ST_HOLD, ST_SCAN: begin
                if (up_p && dn_p) begin
                    r_d.state = ST_BOTH;
                end else if (!act) begin
                    r_d.state = ST_REL;
                    r_d.cnt   = '0;
                end else if (tick) begin
                    if (r_q.cnt == lim) begin
                        step_up   = r_q.dir_up;
                        step_dn   = !r_q.dir_up;
                        r_d.cnt   = '0;
                        r_d.state = (r_q.state == ST_DEB) ? ST_HOLD : ST_SCAN;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_REL: begin
                if (up_p || dn_p) begin
                    r_d.cnt = '0;
                end else if (tick) begin
                    if (r_q.cnt == CW'(REL_TICKS - 1)) r_d.state = ST_IDLE;
                    else                               r_d.cnt   = r_q.cnt + 1'b1;
                end
            end
            ST_BOTH: begin
                if (!up_p && !dn_p) begin
                    r_d.state = ST_REL;
                    r_d.cnt   = '0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, dir_up: 1'b0, cnt: '0};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pos_counter.sv
module pos_counter #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] MID = POS_W'(1) << (POS_W - 1);
    localparam logic [POS_W-1:0] TOP = '1;
    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (inc && pos_q != TOP)           pos_d = pos_q + 1'b1;
        else if (dec && pos_q != '0)       pos_d = pos_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= MID;
        else        pos_q <= pos_d;
    end
    assign pos = pos_q;
endmodule

// File: rtl/stepper_autoscan.sv
module stepper_autoscan #(
    parameter int POS_W           = 6,
    parameter int CLK_PER_TICK    = 100000,
    parameter int DEB_TICKS       = 11,
    parameter int AS_START_TICKS  = 800,
    parameter int AS_PERIOD_TICKS = 250,
    parameter int REL_TICKS       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_n,
    input  logic             dn_n,
    output logic [POS_W-1:0] pos
);
    logic [1:0] pressed;
    logic       tick;
    logic       step_up;
    logic       step_dn;

    btn_sync #(.N(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_n({dn_n, up_n}), .pressed(pressed)
    );

    tick_prescaler #(.CLK_PER_TICK(CLK_PER_TICK)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    step_fsm #(
        .DEB_TICKS(DEB_TICKS), .AS_START_TICKS(AS_START_TICKS),
        .AS_PERIOD_TICKS(AS_PERIOD_TICKS), .REL_TICKS(REL_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .up_p(pressed[0]), .dn_p(pressed[1]),
        .step_up(step_up), .step_dn(step_dn)
    );

    pos_counter #(.POS_W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .inc(step_up), .dec(step_dn), .pos(pos)
    );
endmodule

// File: rtl/stepper_autoscan_chk.sv
module stepper_autoscan_chk #(
    parameter int POS_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_n,
    input logic [POS_W-1:0] pos,
    input logic             tick,
    input logic [1:0]       pressed,
    input logic             step_up,
    input logic             step_dn
);
    localparam logic [POS_W-1:0] TOP = '1;

    a_r1_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> tick);

    a_r6_one_code: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != $past(pos)) |->
        (pos == $past(pos) + POS_W'(1) || pos + POS_W'(1) == $past(pos)));

    a_r6_no_rise_idle_up: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && $past(up_n) && $past(up_n, 2) && $past(up_n, 3)) |-> !(pos > $past(pos)));

    a_r6_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    a_r7_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == TOP && step_up) |=> pos == TOP);

    a_r8_both_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (&pressed) |-> !(step_up || step_dn));
endmodule

bind stepper_autoscan stepper_autoscan_chk #(.POS_W(POS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .pos(pos), .tick(tick),
    .pressed(pressed), .step_up(step_up), .step_dn(step_dn)
);

// File: tb/sim_stepper_autoscan.sv
module sim_stepper_autoscan;
    localparam int W   = 6;
    localparam int TPT = 4;
    localparam int DEB = 5;
    localparam int ASS = 20;
    localparam int PER = 8;
    localparam int REL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_n = 1'b1;
    logic dn_n = 1'b1;
    logic [W-1:0] pos;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stepper_autoscan #(
        .POS_W(W), .CLK_PER_TICK(TPT), .DEB_TICKS(DEB),
        .AS_START_TICKS(ASS), .AS_PERIOD_TICKS(PER), .REL_TICKS(REL)
    ) u0 (.clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n), .pos(pos));

    task automatic ticks(input int n);
        repeat (n * TPT) @(negedge clk);
    endtask

    task automatic chk(input string req, input int exp);
        n_chk++;
        if (int'(pos) != exp) begin
            n_bad++;
            $display("FAIL %s: pos=%0d expected %0d", req, pos, exp);
        end
    endtask

    task automatic t_reset;
        chk("R10", 32);
    endtask

    task automatic t_discrete_up;
        up_n = 1'b0; ticks(3); chk("R1", 32);
        ticks(5); chk("R1", 33);
        up_n = 1'b1; ticks(10); chk("R1", 33);
    endtask

    task automatic t_glitch;
        up_n = 1'b0; ticks(2); up_n = 1'b1; ticks(10); chk("R2", 33);
    endtask

    task automatic t_discrete_dn;
        dn_n = 1'b0; ticks(8); chk("R5", 32);
        dn_n = 1'b1; ticks(10); chk("R5", 32);
    endtask

    task automatic t_scan(input bit up, input int base);
        int s;
        s = up ? 1 : -1;
        if (up) up_n = 1'b0; else dn_n = 1'b0;
        ticks(8);  chk("R1", base + s);
        ticks(14); chk("R3", base + s);
        ticks(6);  chk("R3", base + 2 * s);
        ticks(8);  chk("R4", base + 3 * s);
        ticks(8);  chk("R4", base + 4 * s);
        up_n = 1'b1; dn_n = 1'b1;
        ticks(10); chk("R4", base + 4 * s);
    endtask

    task automatic t_both;
        up_n = 1'b0; dn_n = 1'b0; ticks(20); chk("R8", 32);
        dn_n = 1'b1; ticks(20); chk("R8", 32);
        up_n = 1'b1; ticks(10); chk("R8", 32);
    endtask

    task automatic t_guard;
        up_n = 1'b0; ticks(8); chk("R9", 33);
        up_n = 1'b1; ticks(2);
        up_n = 1'b0; ticks(10); chk("R9", 33);
        up_n = 1'b1; ticks(10);
        up_n = 1'b0; ticks(8); chk("R9", 34);
        up_n = 1'b1; ticks(10);
    endtask

    task automatic t_sat;
        up_n = 1'b0; ticks(400); chk("R7", 63);
        up_n = 1'b1; ticks(10); chk("R7", 63);
        dn_n = 1'b0; ticks(600); chk("R7", 0);
        dn_n = 1'b1; ticks(10); chk("R7", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_discrete_up();
        t_glitch();
        t_discrete_dn();
        t_scan(1'b1, 32);
        t_scan(1'b0, 36);
        t_both();
        t_guard();
        t_sat();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule